// File: doc/BRIEF.md
# Transmit/Receive Bus Access Arbiter

This block decides whether the transmit DMA engine or the receive DMA engine of one channel uses the shared system bus next, for descriptor or buffer transfers. Each engine raises a request line. The arbiter answers with a one-hot grant, and the grant stays in place until the bus side pulses `xfer_done`, which marks the end of the transaction. The block does not model the bus protocol.

A 5-bit policy word picks how contention is settled. Its low bit chooses between two schemes. Under strict priority, the favoured engine always wins. Under weighted round-robin, the favoured engine receives n+1 grants for every single grant to the other engine, with n from 0 to 7, which gives ratios from 1:1 up to 8:1. A second bit names the favoured engine. The favoured engine also wins a simultaneous request at the equal 1:1 weight. The weights only apply while both engines are requesting. A single requester is served at once.

Top module: `txrx_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, both grant outputs are 0.
- R2: At most one of `gnt_tx` and `gnt_rx` is 1 in any cycle.
- R3: When no grant is held and exactly one engine requests, that engine is granted on the next clock edge, in either scheme.
- R4: In strict mode (`policy[0]`=1), simultaneous requests always go to the favoured engine (`policy[1]`=1 for transmit, 0 for receive), and `policy[4:2]` has no effect.
- R5: In weighted mode (`policy[0]`=0), with `policy[4:2]`=n and both engines requesting continuously, grants repeat the pattern n+1 to the favoured engine, then 1 to the other engine.
- R6: In weighted mode with n=0, contended grants alternate between the engines, and the favoured engine receives the first one.
- R7: A grant stays asserted, even if its request falls, until a cycle with `xfer_done`=1. It clears on the following edge, and a new grant can be issued one edge later.
- R8: Any change of the policy word restarts the weight count, so the favoured engine again receives n+1 contended grants before the other engine is served.
- R9: Grants issued to a lone requester do not advance or clear the weight count.
- R10: A `xfer_done` pulse while no grant is held has no effect.
- R11: A grant is issued only to an engine whose request is high at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_tx | input | 1 | Transmit engine bus request |
| req_rx | input | 1 | Receive engine bus request |
| policy | input | 5 | [0] strict=1/weighted=0, [1] favour transmit=1/receive=0, [4:2] weight n |
| xfer_done | input | 1 | One-cycle pulse ending the granted transaction |
| gnt_tx | output | 1 | Bus granted to transmit engine |
| gnt_rx | output | 1 | Bus granted to receive engine |

## Verification
The hardest state to reach from the ports is a weight counter that sits partway through its run just as the policy word changes, because the count is never visible on any output. To reach it, the bench issues two contended grants under one weight. It then drops both requests and changes the policy during an idle cycle. After that it resumes contention and checks that the favoured engine wins a full new run, where a stale count would have handed the next grant to the other engine straight away. In the same way, lone-requester grants are placed between contended ones, and the bench checks that the position in the ratio pattern survives them.

// File: rtl/txrx_arb_pkg.sv
package txrx_arb_pkg;
  parameter int WEIGHT_W = 3;
  localparam int POLICY_W = WEIGHT_W + 2;
  localparam int COUNT_W  = WEIGHT_W + 1;

  typedef enum logic [1:0] {
    OWNER_NONE = 2'd0,
    OWNER_TX   = 2'd1,
    OWNER_RX   = 2'd2
  } owner_t;

  typedef struct packed {
    logic                strict;
    logic                fav_tx;
    logic [WEIGHT_W-1:0] weight;
  } policy_t;
endpackage

// File: rtl/txrx_policy_track.sv
module txrx_policy_track
  import txrx_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [POLICY_W-1:0] policy_in,
  output policy_t             policy_dec,
  output logic                policy_changed
);
  logic [POLICY_W-1:0] policy_q;
  logic [POLICY_W-1:0] policy_d;

  always_comb begin
    policy_d              = policy_in;
    policy_dec.strict     = policy_in[0];
    policy_dec.fav_tx     = policy_in[1];
    policy_dec.weight     = policy_in[POLICY_W-1:2];
    policy_changed        = (policy_in != policy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) policy_q <= '0;
    else        policy_q <= policy_d;
  end
endmodule

// File: rtl/txrx_weight_count.sv
module txrx_weight_count
  import txrx_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                contend,
  input  logic [WEIGHT_W-1:0] weight,
  output logic                pick_fav
);
  logic [COUNT_W-1:0] cnt_q;
  logic [COUNT_W-1:0] cnt_d;
  logic [COUNT_W-1:0] base;
  logic               cnt_en;

  always_comb begin
    base     = restart ? '0 : cnt_q;
    pick_fav = (base <= {1'b0, weight});
    cnt_d    = base;
    if (contend) cnt_d = pick_fav ? base + 1'b1 : '0;
    cnt_en   = restart | contend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txrx_grant_hold.sv
module txrx_grant_hold
  import txrx_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_tx,
  input  logic   req_rx,
  input  logic   win_tx,
  input  logic   xfer_done,
  output owner_t owner
);
  owner_t owner_q;
  owner_t owner_d;
  logic   own_en;

  always_comb begin
    owner_d = owner_q;
    if (owner_q == OWNER_NONE) begin
      if (req_tx && req_rx) owner_d = win_tx ? OWNER_TX : OWNER_RX;
      else if (req_tx)      owner_d = OWNER_TX;
      else if (req_rx)      owner_d = OWNER_RX;
    end else if (xfer_done) begin
      owner_d = OWNER_NONE;
    end
    own_en = (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owner_q <= OWNER_NONE;
    else if (own_en) owner_q <= owner_d;
  end

  assign owner = owner_q;
endmodule

// File: rtl/txrx_bus_arbiter.sv
module txrx_bus_arbiter
  import txrx_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_tx,
  input  logic                req_rx,
  input  logic [POLICY_W-1:0] policy,
  input  logic                xfer_done,
  output logic                gnt_tx,
  output logic                gnt_rx
);
  policy_t pol;
  logic    pol_chg;
  logic    idle;
  logic    contend;
  logic    pick_fav;
  logic    fav_wins;
  logic    win_tx;
  owner_t  owner;

  txrx_policy_track u_policy (
    .clk            (clk),
    .rst_n          (rst_n),
    .policy_in      (policy),
    .policy_dec     (pol),
    .policy_changed (pol_chg)
  );

  assign idle    = (owner == OWNER_NONE);
  assign contend = idle & req_tx & req_rx & ~pol.strict;

  txrx_weight_count u_weight (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (pol_chg),
    .contend  (contend),
    .weight   (pol.weight),
    .pick_fav (pick_fav)
  );

  assign fav_wins = pol.strict | pick_fav;
  assign win_tx   = fav_wins ? pol.fav_tx : ~pol.fav_tx;

  txrx_grant_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_tx    (req_tx),
    .req_rx    (req_rx),
    .win_tx    (win_tx),
    .xfer_done (xfer_done),
    .owner     (owner)
  );

  assign gnt_tx = (owner == OWNER_TX);
  assign gnt_rx = (owner == OWNER_RX);
endmodule

// File: rtl/txrx_bus_arbiter_chk.sv
module txrx_bus_arbiter_chk
  import txrx_arb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_tx,
  input logic                req_rx,
  input logic [POLICY_W-1:0] policy,
  input logic                xfer_done,
  input logic                gnt_tx,
  input logic                gnt_rx
);
  logic none;
  assign none = !gnt_tx && !gnt_rx;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> none);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_tx, gnt_rx}));

  // R3
  lone_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none && req_tx && !req_rx) |=> gnt_tx);

  // R3
  lone_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none && req_rx && !req_tx) |=> gnt_rx);

  // R4
  strict_fav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none && req_tx && req_rx && policy[0]) |=> (gnt_tx == $past(policy[1])) && (gnt_rx != $past(policy[1])));

  // R7
  hold_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_tx && !xfer_done) |=> gnt_tx);

  // R7
  hold_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_rx && !xfer_done) |=> gnt_rx);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!none && xfer_done) |=> none);

  // R11
  no_tx_unasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none && !req_tx) |=> !gnt_tx);

  // R11
  no_rx_unasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none && !req_rx) |=> !gnt_rx);
endmodule

bind txrx_bus_arbiter txrx_bus_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_tx    (req_tx),
  .req_rx    (req_rx),
  .policy    (policy),
  .xfer_done (xfer_done),
  .gnt_tx    (gnt_tx),
  .gnt_rx    (gnt_rx)
);

// File: tb/txrx_bus_arbiter_test.sv
`timescale 1ns/1ps
module txrx_bus_arbiter_test;
  logic       clk;
  logic       rst_n;
  logic       req_tx;
  logic       req_rx;
  logic [4:0] policy;
  logic       xfer_done;
  logic       gnt_tx;
  logic       gnt_rx;
  int         n_chk;
  int         n_bad;

  txrx_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_tx(req_tx), .req_rx(req_rx),
    .policy(policy), .xfer_done(xfer_done), .gnt_tx(gnt_tx), .gnt_rx(gnt_rx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic etx, input logic erx, input string tag);
    n_chk++;
    if (gnt_tx !== etx || gnt_rx !== erx) begin
      n_bad++;
      $display("FAIL %s: gnt_tx/gnt_rx actual %b%b expected %b%b", tag, gnt_tx, gnt_rx, etx, erx);
    end
  endtask

  // starts and ends at a negedge with no grant held
  task automatic serve(input logic rtx, input logic rrx, input logic etx, input logic erx, input string tag);
    req_tx = rtx; req_rx = rrx;
    @(posedge clk); @(negedge clk);
    check(etx, erx, tag);
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
    check(1'b0, 1'b0, {tag, " release"});
  endtask

  task automatic go_idle(input logic [4:0] pol);
    req_tx = 1'b0; req_rx = 1'b0; policy = pol;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_tx = 1'b1; req_rx = 1'b1; xfer_done = 1'b0; policy = 5'b00000;
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b0, "R1 reset");
    req_tx = 1'b0; req_rx = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_lone;
    go_idle(5'b11101);
    serve(1'b1, 1'b0, 1'b1, 1'b0, "R3 lone tx strict");
    serve(1'b0, 1'b1, 1'b0, 1'b1, "R3 lone rx strict");
    go_idle(5'b01010);
    serve(1'b0, 1'b1, 1'b0, 1'b1, "R3 lone rx weighted");
  endtask

  task automatic t_strict;
    go_idle(5'b10101); // favour rx, weight bits set
    for (int i = 0; i < 4; i++) serve(1'b1, 1'b1, 1'b0, 1'b1, "R4 strict rx");
    go_idle(5'b01111); // favour tx
    for (int i = 0; i < 4; i++) serve(1'b1, 1'b1, 1'b1, 1'b0, "R4 strict tx");
  endtask

  task automatic t_ratio(input logic [2:0] n, input logic ftx, input string tag);
    go_idle({n, ftx, 1'b0});
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i <= int'(n); i++) serve(1'b1, 1'b1, ftx, ~ftx, tag);
      serve(1'b1, 1'b1, ~ftx, ftx, tag);
    end
  endtask

  task automatic t_hold;
    go_idle(5'b00011);
    req_tx = 1'b1; req_rx = 1'b0;
    @(posedge clk); @(negedge clk);
    req_tx = 1'b0; req_rx = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check(1'b1, 1'b0, "R7 held without done");
    end
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
    check(1'b0, 1'b0, "R7 cleared after done");
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b1, "R7 regrant after gap");
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_restart;
    go_idle(5'b01100); // n=3 favour rx
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R8 pre rx");
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R8 pre rx");
    go_idle(5'b00100); // n=1 favour rx, count restarts
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R8 restart rx 1");
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R8 restart rx 2");
    serve(1'b1, 1'b1, 1'b1, 0,    "R8 restart tx");
  endtask

  task automatic t_lone_keeps;
    go_idle(5'b00100); // n=1 favour rx
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R9 contended rx");
    serve(1'b1, 1'b0, 1'b1, 1'b0, "R9 lone tx");
    serve(1'b0, 1'b1, 1'b0, 1'b1, "R9 lone rx");
    serve(1'b1, 1'b1, 1'b0, 1'b1, "R9 contended rx 2");
    serve(1'b1, 1'b1, 1'b1, 1'b0, "R9 contended tx");
  endtask

  task automatic t_stray_done;
    go_idle(5'b00001);
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
    check(1'b0, 1'b0, "R10 stray done idle");
    req_rx = 1'b1;
    @(posedge clk); @(negedge clk);
    req_rx = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 1'b1, "R10 later grant held");
    xfer_done = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_done = 1'b0;
    check(1'b0, 1'b0, "R11 no grant without request");
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    fork
      begin
        @(negedge clk);
        t_reset();
        t_lone();
        t_strict();
        t_ratio(3'd2, 1'b0, "R5 rx 3:1");
        t_ratio(3'd7, 1'b1, "R5 tx 8:1");
        t_ratio(3'd0, 1'b1, "R6 equal tx first");
        t_ratio(3'd0, 1'b0, "R6 equal rx first");
        t_hold();
        t_restart();
        t_lone_keeps();
        t_stray_done();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule